// File: doc/BRIEF.md
# Pin-Mapped Word Store

This block is the data store of a small processor. It has one address, read and write port. Most of its address range is plain synchronous word storage. Two fixed windows at the top of the range do something else. In the input window, a read returns the level of an external input pin. In the output window, a write lands in a register that drives an external output pin. A program therefore moves data to and from the outside world with the same load and store operations it uses for memory.

The address space has 256 words of 16 bits. By default, addresses 0 to 239 are storage. Addresses 240 to 247 read input pins 0 to 7, and addresses 248 to 255 drive output pins 0 to 7. Each pin carries 8 bits. On the flat pin buses, pin k occupies bits [8k+7:8k].

Top module: `mmio_pinmap`

## Requirements
- R1: While `rstN` is low, `rdData` and every output pin register clear to zero at each clock edge.
- R2: A write to an address from 0 to 239 stores `wrData`. A read of that address at a later edge puts the stored word on `rdData`, where it is visible right after that edge (one cycle of latency).
- R3: At an edge where `rdEn` is low, `rdData` keeps its previous value.
- R4: A read of address 240+k (k from 0 to 7) returns input pin k, sampled at that edge, in bits 7:0, with bits 15:8 zero.
- R5: A write to an address from 240 to 247 has no effect. No output pin changes, and a later read of that address still returns the input pin.
- R6: A write to address 248+k loads `wrData[7:0]` into output pin k at that edge. All other output pins keep their values.
- R7: A read of address 248+k returns the last value written to output pin k, in bits 7:0, with bits 15:8 zero.
- R8: When a read and a write hit the same address at the same edge, `rdData` shows the value held before the write.
- R9: Writes to storage addresses (0 to 239) leave every output pin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| addr | input | 8 | Word address |
| rdEn | input | 1 | Read request, captured at the clock edge |
| wrEn | input | 1 | Write request, captured at the clock edge |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Registered read data |
| pinsIn | input | 64 | Input pins, 8 bits per pin, pin k at bits [8k+7:8k] |
| pinsOut | output | 64 | Registered output pins, same packing as `pinsIn` |

## Verification
The bench builds the block with its default parameters: 16-bit words, 8-bit addresses, and eight 8-bit pins in each window. With these values the window boundaries fall at 239/240, 247/248 and the last address 255. The bench fills every storage word, then targets each boundary address directly. Eight pins per window fill the 3-bit window index completely, so every pin slice on both buses is exercised. A long random phase then mixes same-address read and write pairs across all three regions.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  // Strobes from the address decoder to the storage datapath
  typedef struct packed {
    logic ramWr;   // write a storage word
    logic ramRd;   // read a storage word
    logic pinRd;   // read an input pin
    logic outRd;   // read back an output pin register
    logic outWr;   // load an output pin register
    logic rdAny;   // any read, so rdData is refreshed
  } accessStrobes_t;
endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
  import mmio_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 8,
  parameter int IDX_W   = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  output accessStrobes_t    strb,
  output logic [IDX_W-1:0]  winIdx
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] OUT_BASE = ADDR_W'(DEPTH - NUM_OUT);
  localparam logic [ADDR_W-1:0] IN_BASE  = ADDR_W'(DEPTH - NUM_OUT - NUM_IN);

  logic inRam, inPins, inOuts;
  logic [ADDR_W-1:0] offIn, offOut;

  always_comb begin
    inOuts = (addr >= OUT_BASE);
    inPins = (addr >= IN_BASE) && !inOuts;
    inRam  = (addr < IN_BASE);
    offIn  = addr - IN_BASE;
    offOut = addr - OUT_BASE;
    winIdx = inOuts ? offOut[IDX_W-1:0] : offIn[IDX_W-1:0];

    strb.ramWr = wrEn && inRam;
    strb.outWr = wrEn && inOuts;
    strb.ramRd = rdEn && inRam;
    strb.pinRd = rdEn && inPins;
    strb.outRd = rdEn && inOuts;
    strb.rdAny = rdEn;
  end
endmodule

// File: rtl/mmio_store.sv
module mmio_store
  import mmio_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int PIN_W     = 8,
  parameter int NUM_IN    = 8,
  parameter int NUM_OUT   = 8,
  parameter int IDX_W     = 3,
  parameter int RAM_DEPTH = 240
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  accessStrobes_t           strb,
  input  logic [IDX_W-1:0]         winIdx,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [NUM_IN*PIN_W-1:0]  pinsIn,
  output logic [DATA_W-1:0]        rdData,
  output logic [NUM_OUT*PIN_W-1:0] pinsOut
);
  localparam int PAD_W = DATA_W - PIN_W;

  logic [DATA_W-1:0] mem [RAM_DEPTH];
  logic [DATA_W-1:0] nextRd;
  logic [PIN_W-1:0]  pinVal, outVal;

  // Plain storage, no reset
  always_ff @(posedge clk) begin
    if (strb.ramWr) mem[addr] <= wrData;
  end

  // One register per output pin
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_outPin
    logic [PIN_W-1:0] pinReg;
    always_ff @(posedge clk) begin
      if (!rstN)                                   pinReg <= '0;
      else if (strb.outWr && winIdx == IDX_W'(g))  pinReg <= wrData[PIN_W-1:0];
    end
    assign pinsOut[g*PIN_W +: PIN_W] = pinReg;
  end

  always_comb begin
    pinVal = pinsIn[winIdx*PIN_W +: PIN_W];
    outVal = pinsOut[winIdx*PIN_W +: PIN_W];
    if (strb.ramRd)      nextRd = mem[addr];
    else if (strb.pinRd) nextRd = {{PAD_W{1'b0}}, pinVal};
    else if (strb.outRd) nextRd = {{PAD_W{1'b0}}, outVal};
    else                 nextRd = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           rdData <= '0;
    else if (strb.rdAny) rdData <= nextRd;
  end
endmodule

// File: rtl/mmio_pinmap.sv
module mmio_pinmap
  import mmio_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int PIN_W   = 8,
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     rdEn,
  input  logic                     wrEn,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdData,
  input  logic [NUM_IN*PIN_W-1:0]  pinsIn,
  output logic [NUM_OUT*PIN_W-1:0] pinsOut
);
  localparam int MAX_WIN   = (NUM_IN > NUM_OUT) ? NUM_IN : NUM_OUT;
  localparam int IDX_W     = (MAX_WIN > 1) ? $clog2(MAX_WIN) : 1;
  localparam int RAM_DEPTH = (1 << ADDR_W) - NUM_IN - NUM_OUT;

  accessStrobes_t   strb;
  logic [IDX_W-1:0] winIdx;

  mmio_decode #(
    .ADDR_W(ADDR_W), .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .IDX_W(IDX_W)
  ) u_decode (
    .addr(addr), .rdEn(rdEn), .wrEn(wrEn), .strb(strb), .winIdx(winIdx)
  );

  mmio_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIN_W(PIN_W), .NUM_IN(NUM_IN),
    .NUM_OUT(NUM_OUT), .IDX_W(IDX_W), .RAM_DEPTH(RAM_DEPTH)
  ) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .winIdx(winIdx), .addr(addr),
    .wrData(wrData), .pinsIn(pinsIn), .rdData(rdData), .pinsOut(pinsOut)
  );
endmodule

// File: rtl/mmio_checker.sv
module mmio_checker #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int PIN_W   = 8,
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [ADDR_W-1:0]        addr,
  input logic                     rdEn,
  input logic                     wrEn,
  input logic [DATA_W-1:0]        wrData,
  input logic [DATA_W-1:0]        rdData,
  input logic [NUM_IN*PIN_W-1:0]  pinsIn,
  input logic [NUM_OUT*PIN_W-1:0] pinsOut
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int OUT_BASE = DEPTH - NUM_OUT;
  localparam int IN_BASE  = OUT_BASE - NUM_IN;

  logic inWinNow, outWinNow;
  assign inWinNow  = (int'(addr) >= IN_BASE) && (int'(addr) < OUT_BASE);
  assign outWinNow = (int'(addr) >= OUT_BASE);

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R3

  AST_PIN_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && inWinNow) |=> rdData == DATA_W'($past(pinsIn[(int'(addr) - IN_BASE)*PIN_W +: PIN_W]))); // R4

  AST_PINS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && outWinNow) |=> $stable(pinsOut)); // R5 R9

  AST_PIN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && outWinNow) |=> pinsOut[(int'($past(addr)) - OUT_BASE)*PIN_W +: PIN_W] == $past(wrData[PIN_W-1:0])); // R6
endmodule

bind mmio_pinmap mmio_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIN_W(PIN_W), .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)
) u_chk (.*);

// File: tb/tb_mmio_pinmap.sv
`timescale 1ns/1ps
module tb_mmio_pinmap;
  localparam int NP = 8;
  logic        clk = 0;
  logic        rstN = 0;
  logic [7:0]  addr = 0;
  logic        rdEn = 0, wrEn = 0;
  logic [15:0] wrData = 0;
  logic [15:0] rdData;
  logic [63:0] pinsIn = 0;
  logic [63:0] pinsOut;

  int checks = 0, errors = 0;
  bit started = 0, done = 0;

  mmio_pinmap dut (.clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
                   .wrData(wrData), .rdData(rdData), .pinsIn(pinsIn), .pinsOut(pinsOut));

  always #4 clk = ~clk;

  // Behavioural reference model
  logic [15:0] ramM [240];
  logic [7:0]  outM [NP];
  logic [15:0] expRd;
  string rdTag, pinTag;

  always @(posedge clk) begin
    if (!rstN) begin
      expRd = 0;
      for (int i = 0; i < NP; i++) outM[i] = 0;
      rdTag = "R1"; pinTag = "R1";
    end else begin
      pinTag = "R9";
      if (rdEn) begin
        if (addr < 240)      begin expRd = ramM[addr]; rdTag = "R2"; end
        else if (addr < 248) begin expRd = {8'h00, pinsIn[(addr-240)*8 +: 8]}; rdTag = "R4"; end
        else                 begin expRd = {8'h00, outM[addr-248]}; rdTag = "R7"; end
        if (wrEn) rdTag = "R8";
      end else rdTag = "R3";
      if (wrEn) begin
        if (addr < 240)      ramM[addr] = wrData;
        else if (addr < 248) pinTag = "R5";
        else begin outM[addr-248] = wrData[7:0]; pinTag = "R6"; end
      end
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      logic [63:0] expPins;
      for (int i = 0; i < NP; i++) expPins[i*8 +: 8] = outM[i];
      checks++;
      if (rdData !== expRd) begin
        errors++;
        $display("FAIL %s rdData actual %h expected %h", rdTag, rdData, expRd);
      end
      checks++;
      if (pinsOut !== expPins) begin
        errors++;
        $display("FAIL %s pinsOut actual %h expected %h", pinTag, pinsOut, expPins);
      end
    end
  end

  task automatic cyc(input logic r, input logic w, input logic [7:0] a, input logic [15:0] d);
    rdEn = r; wrEn = w; addr = a; wrData = d;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);                     // R1 reset state
    rstN = 1;
    for (int a = 0; a < 240; a++) cyc(0, 1, 8'(a), 16'(a * 257) ^ 16'h5a5a); // R2 fill
    cyc(1, 0, 0, 0); cyc(1, 0, 239, 0); cyc(1, 0, 117, 0);                    // R2
    cyc(0, 0, 0, 0); cyc(0, 0, 239, 0);                                       // R3 hold
    pinsIn = 64'h8877_6655_4433_2211;
    for (int k = 0; k < 8; k++) cyc(1, 0, 8'(240 + k), 0);                    // R4
    pinsIn = 64'hff00_a5c3_0f7e_01fe;
    cyc(1, 0, 240, 0); cyc(1, 0, 247, 0);                                     // R4 fresh sample
    for (int k = 0; k < 8; k++) cyc(0, 1, 8'(240 + k), 16'hdead);             // R5
    cyc(1, 0, 243, 0);                                                        // R5 still pin
    for (int k = 0; k < 8; k++) cyc(0, 1, 8'(248 + k), 16'(16'h1230 + k * 16'h1111)); // R6
    for (int k = 0; k < 8; k++) cyc(1, 0, 8'(248 + k), 0);                    // R7
    cyc(0, 1, 5, 16'hbeef);                                                   // R9
    cyc(1, 1, 5, 16'h0001); cyc(1, 0, 5, 0);                                  // R8 RAM
    cyc(1, 1, 255, 16'h00aa); cyc(1, 0, 255, 0);                              // R8 output
    for (int n = 0; n < 3000; n++) begin
      if (n % 97 == 0) pinsIn = {$urandom, $urandom};
      cyc(1'($urandom), 1'($urandom), 8'($urandom), 16'($urandom));
    end
    rstN = 0; cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);                               // R1 mid-run
    rstN = 1; cyc(1, 0, 250, 0);                                              // R7 after clear
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule